// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a pipelined CPU and a data memory port that is addressed by whole words. The memory never sees the two lowest address bits. This block uses them instead. On a load it takes the full word that memory returned and moves the addressed byte or halfword down into the lowest lanes. Every bit above the selected field is cleared. The CPU then decides whether to sign-extend or zero-extend the result. On a store it does the reverse: the low-order CPU data is moved up into the addressed lanes, and one write strobe per byte lane is raised for the lanes that memory must update.

The unit is purely combinational, so its outputs follow the inputs in the same cycle. The access size is chosen by a two-bit mode. A halfword access with an odd offset, or a word access with any nonzero offset, is flagged as misaligned. The data paths then behave as if the offending low offset bits were zero. Lanes are numbered little-endian, with lane 0 holding bits 7:0.

Top module: `lane_align_unit`

## Requirements
- R1: Mode 2'b10 (word) with offset 2'b00 passes the load word to the load output and the store data to the store output unchanged, with strobes 4'b1111 and no misaligned flag.
- R2: Mode 2'b01 (halfword) with offset 2'b00 returns {16'h0, word[15:0]}, and with offset 2'b10 returns {16'h0, word[31:16]}.
- R3: Mode 2'b00 (byte) returns {24'h0, word[8*offset+7 : 8*offset]} for each of the four offsets. For example, word 0x87654321 yields 0x21, 0x43, 0x65 and 0x87 for offsets 0 to 3.
- R4: In byte mode, store data bits 7:0 appear in lane number offset, all other store lanes are zero, and the strobes equal 4'b0001 shifted left by offset.
- R5: In halfword mode, store data bits 15:0 occupy lanes 1:0 with strobes 4'b0011 for offset 2'b00, or lanes 3:2 with strobes 4'b1100 for offset 2'b10. The other lanes are zero.
- R6: The misaligned flag is 1 exactly when the mode is halfword and offset bit 0 is 1, or when the mode is word (2'b10 or 2'b11) and the offset is nonzero. Byte mode never raises it.
- R7: On a misaligned access, all three data outputs equal those of the same mode with the offending offset bits cleared. Halfword offsets 01 and 11 act as 00 and 10. Word mode acts as offset 00.
- R8: Mode 2'b11 behaves exactly as word mode on every output, including the misaligned flag.
- R9: No clock is involved. Outputs reflect the current inputs, and with all inputs zero the load and store outputs are zero, the strobes are 4'b0001 and the flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 treated as word |
| offset_i | input | 2 | Low address bits selecting the byte lane |
| ld_word_i | input | 32 | Word read from memory |
| st_data_i | input | 32 | Store data from the CPU, right-justified |
| ld_data_o | output | 32 | Aligned load data, zero above the selected field |
| st_data_o | output | 32 | Store data moved to the addressed lanes |
| st_strb_o | output | 4 | Per-lane write strobes, bit k enables bits 8k+7:8k |
| misalign_o | output | 1 | Set when the offset does not suit the access size |

## Verification
The immediate assertions assume only that mode and offset are known two-bit values; every one of the sixteen combinations is legal, so nothing is excluded. They also assume the checks are taken once the combinational outputs have settled after an input change. The bench ensures this by driving inputs just after a rising clock edge and comparing at the following falling edge. It sweeps all sixteen mode and offset pairs against fixed patterns (0x87654321, all ones, all zeros, alternating bits) and against pseudo-random words, so the stimulus never leaves the assumed domain.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

    localparam int unsigned ALN_DATA_W = 32;
    localparam int unsigned ALN_LANE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } align_mode_e;

    // Number of byte lanes an access of the given size covers.
    function automatic int unsigned mode_lanes(align_mode_e m, int unsigned nlanes);
        case (m)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return nlanes;
        endcase
    endfunction

endpackage

// File: rtl/lane_size_decode.sv
module lane_size_decode
    import lane_align_pkg::*;
#(
    parameter int unsigned NLANES = 4,
    localparam int unsigned OFF_W = $clog2(NLANES)
) (
    input  align_mode_e        mode,
    input  logic [OFF_W-1:0]   offset,
    output logic [OFF_W-1:0]   eff_off,
    output logic [OFF_W:0]     nlanes,
    output logic               misalign
);
    logic [OFF_W-1:0] low_mask;

    always_comb begin
        nlanes   = (OFF_W+1)'(mode_lanes(mode, NLANES));
        low_mask = OFF_W'(nlanes - 1'b1);
        eff_off  = offset & ~low_mask;
        misalign = |(offset & low_mask);
    end

    always_comb begin
        // R6
        byte_never_misaligned_chk: assert (!(mode == SZ_BYTE && misalign))
            else $error("byte access flagged misaligned");
        // R7
        eff_aligned_chk: assert ((eff_off & low_mask) == '0)
            else $error("effective offset not aligned to access size");
    end
endmodule

// File: rtl/lane_load_shift.sv
module lane_load_shift #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned NLANES = DATA_W / LANE_W,
    localparam int unsigned OFF_W  = $clog2(NLANES)
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [OFF_W-1:0]  eff_off,
    input  logic [OFF_W:0]    nlanes,
    output logic [DATA_W-1:0] data_out
);
    logic [LANE_W-1:0] in_lane [NLANES];

    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        localparam logic [OFF_W-1:0] KO = OFF_W'(k);
        localparam logic [OFF_W:0]   KN = (OFF_W+1)'(k);
        logic [OFF_W-1:0] src;
        assign in_lane[k] = word_in[k*LANE_W +: LANE_W];
        assign src        = eff_off + KO;
        assign data_out[k*LANE_W +: LANE_W] = (KN < nlanes) ? in_lane[src] : '0;
    end

    always_comb begin
        // R3
        ld_zero_fill_chk: assert (nlanes != 1 || data_out[DATA_W-1:LANE_W] == '0)
            else $error("byte load left upper lanes nonzero");
        // R2
        ld_half_fill_chk: assert (nlanes != 2 || data_out[DATA_W-1:2*LANE_W] == '0)
            else $error("halfword load left upper lanes nonzero");
    end
endmodule

// File: rtl/lane_store_place.sv
module lane_store_place #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned NLANES = DATA_W / LANE_W,
    localparam int unsigned OFF_W  = $clog2(NLANES)
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [OFF_W-1:0]  eff_off,
    input  logic [OFF_W:0]    nlanes,
    output logic [DATA_W-1:0] data_out,
    output logic [NLANES-1:0] strb
);
    logic [LANE_W-1:0] in_lane [NLANES];

    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        localparam logic [OFF_W-1:0] KO = OFF_W'(k);
        logic [OFF_W-1:0] rel;
        assign in_lane[k] = data_in[k*LANE_W +: LANE_W];
        assign rel        = KO - eff_off;
        assign strb[k]    = ({1'b0, rel} < nlanes);
        assign data_out[k*LANE_W +: LANE_W] = strb[k] ? in_lane[rel] : '0;
    end

    always_comb begin
        for (int k = 0; k < NLANES; k++) begin
            // R4
            st_lane_quiet_chk: assert (strb[k] || data_out[k*LANE_W +: LANE_W] == '0)
                else $error("store lane %0d driven without strobe", k);
        end
        // R5
        st_strb_count_chk: assert ($countones(strb) == int'(nlanes))
            else $error("strobe count does not match access size");
    end
endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
    import lane_align_pkg::*;
#(
    parameter int unsigned DATA_W = ALN_DATA_W,
    parameter int unsigned LANE_W = ALN_LANE_W,
    localparam int unsigned NLANES = DATA_W / LANE_W,
    localparam int unsigned OFF_W  = $clog2(NLANES)
) (
    input  logic [1:0]        mode_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [DATA_W-1:0] ld_word_i,
    input  logic [DATA_W-1:0] st_data_i,
    output logic [DATA_W-1:0] ld_data_o,
    output logic [DATA_W-1:0] st_data_o,
    output logic [NLANES-1:0] st_strb_o,
    output logic              misalign_o
);
    align_mode_e      mode;
    logic [OFF_W-1:0] eff_off;
    logic [OFF_W:0]   nlanes;

    assign mode = align_mode_e'(mode_i);

    lane_size_decode #(.NLANES(NLANES)) u_decode (
        .mode     (mode),
        .offset   (offset_i),
        .eff_off  (eff_off),
        .nlanes   (nlanes),
        .misalign (misalign_o)
    );

    lane_load_shift #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_load (
        .word_in  (ld_word_i),
        .eff_off  (eff_off),
        .nlanes   (nlanes),
        .data_out (ld_data_o)
    );

    lane_store_place #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_store (
        .data_in  (st_data_i),
        .eff_off  (eff_off),
        .nlanes   (nlanes),
        .data_out (st_data_o),
        .strb     (st_strb_o)
    );

    always_comb begin
        // R1
        word_passthru_chk: assert (!(mode_i[1] && !misalign_o) || ld_data_o == ld_word_i)
            else $error("aligned word load altered data");
        // R8
        word_strb_full_chk: assert (!mode_i[1] || &st_strb_o)
            else $error("word access missing strobes");
        // R6
        misalign_off_chk: assert (!misalign_o || offset_i != '0)
            else $error("misaligned flag with zero offset");
    end
endmodule

// File: tb/lane_align_unit_bench.sv
module lane_align_unit_bench;

    typedef struct {
        logic [31:0] ld;
        logic [31:0] st;
        logic [3:0]  strb;
        logic        mis;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = '0;
    logic [1:0]  offset_i = '0;
    logic [31:0] ld_word_i = '0;
    logic [31:0] st_data_i = '0;
    logic [31:0] ld_data_o, st_data_o;
    logic [3:0]  st_strb_o;
    logic        misalign_o;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #5 clk = ~clk;

    lane_align_unit u_lane_align_unit (
        .mode_i     (mode_i),
        .offset_i   (offset_i),
        .ld_word_i  (ld_word_i),
        .st_data_i  (st_data_i),
        .ld_data_o  (ld_data_o),
        .st_data_o  (st_data_o),
        .st_strb_o  (st_strb_o),
        .misalign_o (misalign_o)
    );

    // Reference model written from the requirement text as explicit cases.
    function automatic exp_t model(logic [1:0] m, logic [1:0] o, logic [31:0] w, logic [31:0] d);
        exp_t e;
        e.mis = 1'b0;
        case (m)
            2'b00: begin
                e.tag = "R3,R4";
                case (o)
                    2'd0: begin e.ld = {24'h0, w[7:0]};   e.st = {24'h0, d[7:0]};        e.strb = 4'b0001; end
                    2'd1: begin e.ld = {24'h0, w[15:8]};  e.st = {16'h0, d[7:0], 8'h0};  e.strb = 4'b0010; end
                    2'd2: begin e.ld = {24'h0, w[23:16]}; e.st = {8'h0, d[7:0], 16'h0};  e.strb = 4'b0100; end
                    default: begin e.ld = {24'h0, w[31:24]}; e.st = {d[7:0], 24'h0};     e.strb = 4'b1000; end
                endcase
            end
            2'b01: begin
                e.mis = o[0];
                e.tag = o[0] ? "R6,R7" : "R2,R5";
                if (o[1]) begin
                    e.ld = {16'h0, w[31:16]}; e.st = {d[15:0], 16'h0}; e.strb = 4'b1100;
                end else begin
                    e.ld = {16'h0, w[15:0]};  e.st = {16'h0, d[15:0]}; e.strb = 4'b0011;
                end
            end
            default: begin
                e.ld = w; e.st = d; e.strb = 4'b1111;
                e.mis = (o != 2'b00);
                if (m == 2'b11) e.tag = "R8";
                else e.tag = (o != 2'b00) ? "R6,R7" : "R1";
            end
        endcase
        return e;
    endfunction

    task automatic drive(logic [1:0] m, logic [1:0] o, logic [31:0] w, logic [31:0] d, string tag_override);
        exp_t e;
        @(posedge clk);
        #1;
        mode_i = m; offset_i = o; ld_word_i = w; st_data_i = d;
        e = model(m, o, w, d);
        if (tag_override != "") e.tag = tag_override;
        exp_q.push_back(e);
    endtask

    // Monitor: compares at the falling edge, after inputs have settled.
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            bit bad;
            e = exp_q.pop_front();
            bad = 1'b0;
            n_cmp++;
            if (ld_data_o !== e.ld) begin
                $display("FAIL %s ld_data actual=%h expected=%h (mode=%b off=%b)", e.tag, ld_data_o, e.ld, mode_i, offset_i);
                bad = 1'b1;
            end
            if (st_data_o !== e.st) begin
                $display("FAIL %s st_data actual=%h expected=%h (mode=%b off=%b)", e.tag, st_data_o, e.st, mode_i, offset_i);
                bad = 1'b1;
            end
            if (st_strb_o !== e.strb) begin
                $display("FAIL %s st_strb actual=%b expected=%b (mode=%b off=%b)", e.tag, st_strb_o, e.strb, mode_i, offset_i);
                bad = 1'b1;
            end
            if (misalign_o !== e.mis) begin
                $display("FAIL %s misalign actual=%b expected=%b (mode=%b off=%b)", e.tag, misalign_o, e.mis, mode_i, offset_i);
                bad = 1'b1;
            end
            if (bad) n_bad++;
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h8765_4321;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h0000_0000;
        pats[3] = 32'hA5A5_5A5A;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R9: all inputs zero
        drive(2'b00, 2'b00, 32'h0, 32'h0, "R9");
        // R3: worked example, each byte of 0x87654321
        for (int o = 0; o < 4; o++) drive(2'b00, 2'(o), 32'h8765_4321, 32'h0000_00C7, "R3");
        // R2: halfword worked example
        drive(2'b01, 2'b00, 32'h8765_4321, 32'h0000_BEEF, "R2");
        drive(2'b01, 2'b10, 32'h8765_4321, 32'h0000_BEEF, "R2");
        // Full sweep over modes and offsets with fixed patterns
        for (int p = 0; p < 4; p++)
            for (int m = 0; m < 4; m++)
                for (int o = 0; o < 4; o++)
                    drive(2'(m), 2'(o), pats[p], ~pats[(p + 1) % 4], "");
        // Pseudo-random words
        for (int i = 0; i < 64; i++)
            drive(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), $urandom, $urandom, "");
        @(posedge clk);
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule